// File: doc/BRIEF.md
# Debug Port Acquire Window Controller

This block decides, after every reset, which of two candidate pin pairs becomes the active two-wire debug port, if either does. The primary pair carries the four-wire test interface's mode and clock pins. The secondary pair carries the USB data pins. For a fixed key window after reset release, the block watches both pairs. On each pair, a clock pin clocks in a fixed 16-bit acquire pattern, most significant bit first, on rising edges. The first pair to deliver the complete pattern inside the window owns the port. The other pair is ignored from then on.

A non-volatile configuration bit can pre-select two-wire debug on the primary pair. In that case the primary pair is enabled right after reset, with no pattern. The secondary pair always has to send the pattern. A register write from the four-wire test interface can enable the port or disable it. Disabling hands both pairs back to GPIO. The pin-mux outputs tell the pad logic which pins the debug port owns.

All pins are asynchronous to the system clock. Each pin is passed through a two-flop synchroniser before edge detection. This lets a pin clock as fast as one third of the system clock be followed without loss.

Top module: `dbg_acq_ctrl`

## Requirements
- R1: The key window is open for WIN_CYCLES = SYS_CLK_MHZ*WINDOW_US system clocks after reset release (800 by default), and `windowOpen` is 1 exactly while it is open. A pattern whose last bit arrives after the window has closed leaves `portEn`=0 and `portSel`=00.
- R2: With the port disabled and the window open, the pattern 16'hA5E3 on the primary pair gives `portEn`=1, `portSel`=01, `priMuxDbg`=1 and `secMuxDbg`=0. The pattern is shifted MSB first, with the data pin sampled at the clock pin's rising edges.
- R3: Under the same conditions, the pattern on the secondary pair gives `portEn`=1, `portSel`=10, `secMuxDbg`=1 and `priMuxDbg`=0.
- R4: Once a pair owns the port, a full pattern on the other pair changes neither `portSel` nor the mux outputs.
- R5: If `nvlDbgSel`=1 at reset release, the primary pair is enabled (`portSel`=01) without any pattern.
- R6: The secondary pair is never enabled without the exact pattern. A pattern with its last bit inverted, or no pattern at all, leaves the port disabled.
- R7: A test-interface write (`tapWrEn`=1) with `tapWrVal`=1 enables the port. It selects the primary pair if no pair was selected and otherwise keeps the current pair. A write with `tapWrVal`=0 clears `portEn`, sets `portSel`=00 and drops both mux outputs to 0 (GPIO).
- R8: After a disable, the port can be acquired again while the window of the same reset is still open, and also in the window of any later reset.
- R9: A pin clock with a period of three system clocks (one high, two low) is followed bit for bit.
- R10: If both pairs complete the pattern in the same system clock cycle, the primary pair wins (`portSel`=01).
- R11: After reset release the outputs read `portEn`=0, `portSel`=00, both muxes 0 and `windowOpen`=1 when `nvlDbgSel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; the window starts at its release |
| nvlDbgSel | input | 1 | Latched configuration bit pre-enabling the primary pair |
| priClkPin | input | 1 | Primary pair clock pin (asynchronous) |
| priDataPin | input | 1 | Primary pair data pin (asynchronous) |
| secClkPin | input | 1 | Secondary pair clock pin (asynchronous) |
| secDataPin | input | 1 | Secondary pair data pin (asynchronous) |
| tapWrEn | input | 1 | Test-interface write strobe for the port-enable bit |
| tapWrVal | input | 1 | Value written: 1 enables, 0 disables |
| portEn | output | 1 | Debug port enabled |
| portSel | output | 2 | Owning pair: 00 none, 01 primary, 10 secondary |
| priMuxDbg | output | 1 | Primary pins given to debug (0 = GPIO) |
| secMuxDbg | output | 1 | Secondary pins given to debug (0 = GPIO) |
| windowOpen | output | 1 | Key window still open |

## Verification
The hardest conditions to reach from the ports are a same-cycle finish on both pairs and a pattern that ends right at the edge of the window. A single pattern task drives any mask of the two pairs in exact lockstep, so both pairs finish on the same system clock. Table entries also carry a start delay, which places the last bit either just inside the 800-cycle window or well past it. Every pattern is sent at the fastest allowed pin clock (one high cycle, two low), so edge detection is exercised at its limit throughout.

// File: rtl/dbg_acq_pkg.sv
package dbg_acq_pkg;
  typedef enum logic [1:0] {
    PAIR_NONE = 2'b00,
    PAIR_PRI  = 2'b01,
    PAIR_SEC  = 2'b10
  } pair_e;

  // control -> datapath
  typedef struct packed {
    logic priShiftEn;
    logic secShiftEn;
  } ctrl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic priHit;
    logic secHit;
    logic winOpen;
  } dp_status_t;
endpackage

// File: rtl/dbg_acq_lane.sv
module dbg_acq_lane #(
  parameter int unsigned PAT_W = 16,
  parameter logic [PAT_W-1:0] PATTERN = 16'hA5E3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinClk,
  input  logic pinData,
  input  logic shiftEn,
  output logic hit
);
  localparam int unsigned SMSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic                   clkPrev;
  logic [PAT_W-1:0]       shiftReg;
  logic [PAT_W-1:0]       nextShift;
  logic                   rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
      clkPrev  <= 1'b0;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], pinClk};
      dataSync <= {dataSync[SYNC_STAGES-2:0], pinData};
      clkPrev  <= clkSync[SMSB];
    end
  end

  assign rise      = clkSync[SMSB] & ~clkPrev;
  assign nextShift = {shiftReg[PAT_W-2:0], dataSync[SMSB]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (rise && shiftEn) shiftReg <= nextShift;
  end

  assign hit = rise && shiftEn && (nextShift == PATTERN);
endmodule

// File: rtl/dbg_acq_datapath.sv
module dbg_acq_datapath
  import dbg_acq_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 800,
  parameter int unsigned PAT_W = 16,
  parameter logic [PAT_W-1:0] PATTERN = 16'hA5E3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   pairClk,
  input  logic [1:0]   pairData,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status
);
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);

  logic [CNT_W-1:0] winCnt;
  logic             winOpen;
  logic [1:0]       laneEn;
  logic [1:0]       laneHit;

  assign winOpen = (winCnt < CNT_W'(WIN_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        winCnt <= '0;
    else if (winOpen) winCnt <= winCnt + 1'b1;
  end

  assign laneEn = {strobe.secShiftEn, strobe.priShiftEn};

  // lane 0 = primary pair, lane 1 = secondary pair
  for (genvar g = 0; g < 2; g++) begin : g_lane
    dbg_acq_lane #(
      .PAT_W(PAT_W), .PATTERN(PATTERN), .SYNC_STAGES(SYNC_STAGES)
    ) u_lane (
      .clk(clk), .rstN(rstN),
      .pinClk(pairClk[g]), .pinData(pairData[g]),
      .shiftEn(laneEn[g]), .hit(laneHit[g])
    );
  end

  assign status.priHit  = laneHit[0];
  assign status.secHit  = laneHit[1];
  assign status.winOpen = winOpen;

  // R1: a closed window never reopens until the next reset
  p_window_stays_closed_r1: assert property (@(posedge clk) disable iff (!rstN)
    !winOpen |=> !winOpen);
  // R1: no lane shifts outside the window
  p_no_shift_outside_r1: assert property (@(posedge clk) disable iff (!rstN)
    !winOpen |-> (laneHit == 2'b00));
endmodule

// File: rtl/dbg_acq_control.sv
module dbg_acq_control
  import dbg_acq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dp_status_t   status,
  input  logic         nvlDbgSel,
  input  logic         tapWrEn,
  input  logic         tapWrVal,
  output ctrl_strobe_t strobe,
  output logic         portEn,
  output pair_e        portSel,
  output logic         priMuxDbg,
  output logic         secMuxDbg
);
  logic  bootQ;
  logic  enQ;
  pair_e selQ;
  logic  acqArmed;

  assign acqArmed          = !enQ && status.winOpen;
  assign strobe.priShiftEn = acqArmed;
  assign strobe.secShiftEn = acqArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootQ <= 1'b1;
      enQ   <= 1'b0;
      selQ  <= PAIR_NONE;
    end else begin
      bootQ <= 1'b0;
      if (bootQ && nvlDbgSel) begin
        enQ  <= 1'b1;
        selQ <= PAIR_PRI;
      end else if (tapWrEn) begin
        if (tapWrVal) begin
          enQ <= 1'b1;
          if (selQ == PAIR_NONE) selQ <= PAIR_PRI;
        end else begin
          enQ  <= 1'b0;
          selQ <= PAIR_NONE;
        end
      end else if (acqArmed && status.priHit) begin
        enQ  <= 1'b1;
        selQ <= PAIR_PRI;
      end else if (acqArmed && status.secHit) begin
        enQ  <= 1'b1;
        selQ <= PAIR_SEC;
      end
    end
  end

  assign portEn    = enQ;
  assign portSel   = selQ;
  assign priMuxDbg = enQ && (selQ == PAIR_PRI);
  assign secMuxDbg = enQ && (selQ == PAIR_SEC);

  // R1: enabling without a write or boot preset only happens inside the window
  p_acq_in_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enQ) |-> ($past(status.winOpen) || $past(tapWrEn) || $past(bootQ)));
  // R4: an owning pair keeps the port unless the test interface writes
  p_owner_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !tapWrEn) |=> (enQ && $stable(selQ)));
  // R6: the secondary pair is only taken on a completed pattern
  p_sec_needs_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secMuxDbg) |-> $past(status.secHit));
  // R10: a same-cycle finish on both pairs goes to the primary pair
  p_tie_primary_r10: assert property (@(posedge clk) disable iff (!rstN)
    (acqArmed && status.priHit && status.secHit && !tapWrEn && !bootQ) |=> (selQ == PAIR_PRI));
  // R7: never two pin pairs muxed to debug
  p_single_mux_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({priMuxDbg, secMuxDbg}));
endmodule

// File: rtl/dbg_acq_ctrl.sv
module dbg_acq_ctrl
  import dbg_acq_pkg::*;
#(
  parameter int unsigned SYS_CLK_MHZ = 100,
  parameter int unsigned WINDOW_US = 8,
  parameter int unsigned PAT_W = 16,
  parameter logic [PAT_W-1:0] PATTERN = 16'hA5E3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nvlDbgSel,
  input  logic       priClkPin,
  input  logic       priDataPin,
  input  logic       secClkPin,
  input  logic       secDataPin,
  input  logic       tapWrEn,
  input  logic       tapWrVal,
  output logic       portEn,
  output logic [1:0] portSel,
  output logic       priMuxDbg,
  output logic       secMuxDbg,
  output logic       windowOpen
);
  localparam int unsigned WIN_CYCLES = SYS_CLK_MHZ * WINDOW_US;

  ctrl_strobe_t strobe;
  dp_status_t   status;
  pair_e        selInt;

  dbg_acq_datapath #(
    .WIN_CYCLES(WIN_CYCLES), .PAT_W(PAT_W), .PATTERN(PATTERN), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .pairClk({secClkPin, priClkPin}),
    .pairData({secDataPin, priDataPin}),
    .strobe(strobe), .status(status)
  );

  dbg_acq_control u_ctl (
    .clk(clk), .rstN(rstN), .status(status),
    .nvlDbgSel(nvlDbgSel), .tapWrEn(tapWrEn), .tapWrVal(tapWrVal),
    .strobe(strobe), .portEn(portEn), .portSel(selInt),
    .priMuxDbg(priMuxDbg), .secMuxDbg(secMuxDbg)
  );

  assign portSel    = selInt;
  assign windowOpen = status.winOpen;
endmodule

// File: tb/dbg_acq_ctrl_bench.sv
module dbg_acq_ctrl_bench;
  localparam logic [15:0] PAT = 16'hA5E3;
  localparam int WIN = 800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nvlDbgSel = 1'b0;
  logic priClkPin = 1'b0, priDataPin = 1'b0, secClkPin = 1'b0, secDataPin = 1'b0;
  logic tapWrEn = 1'b0, tapWrVal = 1'b0;
  logic portEn, priMuxDbg, secMuxDbg, windowOpen;
  logic [1:0] portSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_acq_ctrl u_dbg_acq_ctrl (
    .clk(clk), .rstN(rstN), .nvlDbgSel(nvlDbgSel),
    .priClkPin(priClkPin), .priDataPin(priDataPin),
    .secClkPin(secClkPin), .secDataPin(secDataPin),
    .tapWrEn(tapWrEn), .tapWrVal(tapWrVal),
    .portEn(portEn), .portSel(portSel),
    .priMuxDbg(priMuxDbg), .secMuxDbg(secMuxDbg), .windowOpen(windowOpen)
  );

  typedef struct packed {
    logic        nvl;
    logic [1:0]  mask;    // bit0 primary, bit1 secondary
    logic        bad;     // invert last bit
    logic [15:0] delay;   // cycles after reset before the pattern
    logic [1:0]  expSel;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b01, 1'b0, 16'd0,   2'b01},  // R2 primary
    '{1'b0, 2'b10, 1'b0, 16'd0,   2'b10},  // R3 secondary
    '{1'b0, 2'b11, 1'b0, 16'd0,   2'b01},  // R10 tie
    '{1'b1, 2'b00, 1'b0, 16'd0,   2'b01},  // R5 preset
    '{1'b0, 2'b00, 1'b0, 16'd0,   2'b00},  // R6 nothing sent
    '{1'b0, 2'b10, 1'b1, 16'd0,   2'b00},  // R6 corrupted
    '{1'b0, 2'b01, 1'b0, 16'd900, 2'b00},  // R1 too late
    '{1'b1, 2'b10, 1'b0, 16'd0,   2'b01},  // R4 preset owner holds
    '{1'b0, 2'b01, 1'b0, 16'd700, 2'b01}   // R1 just inside
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic nvl);
    @(negedge clk);
    rstN = 1'b0;
    nvlDbgSel = nvl;
    priClkPin = 0; priDataPin = 0; secClkPin = 0; secDataPin = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one high cycle, two low cycles per bit: the fastest allowed pin clock
  task automatic sendPattern(input logic [1:0] mask, input logic bad);
    for (int i = 15; i >= 0; i--) begin
      logic b;
      b = PAT[i] ^ (bad && (i == 0));
      @(negedge clk);
      if (mask[0]) begin priClkPin = 0; priDataPin = b; end
      if (mask[1]) begin secClkPin = 0; secDataPin = b; end
      repeat (2) @(negedge clk);
      if (mask[0]) priClkPin = 1;
      if (mask[1]) secClkPin = 1;
    end
    @(negedge clk);
    priClkPin = 0; secClkPin = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic tapWrite(input logic v);
    @(negedge clk);
    tapWrEn = 1'b1; tapWrVal = v;
    @(negedge clk);
    tapWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic outs(input string req, input logic en, input logic [1:0] sel);
    chk(req, {4'b0, portEn, priMuxDbg, secMuxDbg, 1'b0},
             {4'b0, en, en && sel == 2'b01, en && sel == 2'b10, 1'b0});
    chk(req, {6'b0, portSel}, {6'b0, sel});
  endtask

  initial begin
    // R11 reset state
    doReset(1'b0);
    @(negedge clk);
    outs("R11", 1'b0, 2'b00);
    chk("R11 windowOpen", {7'b0, windowOpen}, 8'd1);

    // table, all patterns at the 1/3 pin clock (R9)
    for (int i = 0; i < NV; i++) begin
      doReset(VECS[i].nvl);
      repeat (VECS[i].delay) @(negedge clk);
      if (VECS[i].mask != 2'b00) sendPattern(VECS[i].mask, VECS[i].bad);
      else repeat (60) @(negedge clk);
      outs($sformatf("R9 vec%0d", i), VECS[i].expSel != 2'b00, VECS[i].expSel);
      if (i == 6) chk("R1 window closed", {7'b0, windowOpen}, 8'd0);
    end

    // R4: secondary owns, primary pattern later ignored
    doReset(1'b0);
    sendPattern(2'b10, 1'b0);
    outs("R3 before R4", 1'b1, 2'b10);
    sendPattern(2'b01, 1'b0);
    outs("R4", 1'b1, 2'b10);

    // R7: write enable keeps current pair, disable returns to GPIO
    tapWrite(1'b1);
    outs("R7 keep", 1'b1, 2'b10);
    tapWrite(1'b0);
    outs("R7 off", 1'b0, 2'b00);

    // R8: reacquire within the same window after disable
    sendPattern(2'b10, 1'b0);
    outs("R8 same window", 1'b1, 2'b10);
    tapWrite(1'b0);
    repeat (WIN) @(negedge clk);
    chk("R1 closed", {7'b0, windowOpen}, 8'd0);
    sendPattern(2'b01, 1'b0);
    outs("R1 late ignored", 1'b0, 2'b00);

    // R7: enable from nothing selects primary
    tapWrite(1'b1);
    outs("R7 on", 1'b1, 2'b01);
    tapWrite(1'b0);

    // R8: acquire in the next reset window after disable
    doReset(1'b0);
    sendPattern(2'b01, 1'b0);
    outs("R8 next reset", 1'b1, 2'b01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule